// File: doc/BRIEF.md
# Asynchronous Memory Access Sequencer

This block turns one access request into the strobe timing that a slow, memory-mapped external device needs. A request brings an address, write data, a bank index and a direction, together with three timing settings: a wait-state count, an acknowledge enable and a post-write hold count. The sequencer drives the read or write strobe for the programmed number of cycles. When acknowledge is enabled, it keeps the strobe asserted until the device raises its acknowledge input.

After a write, the sequencer can keep the address, the write data and the bank select on the bus for a few more cycles with both strobes low, so that slow devices get extra hold time. A read captures the device data on the last strobe cycle. Every access ends with a one-cycle done pulse. The block then returns to idle, and only in idle does it accept the next request.

Top module: `async_mem_seq`

## Requirements
- R1: With acknowledge disabled, a wait-state value `cfg_wait` from 1 to 31 keeps the strobe asserted for exactly that many cycles, starting in the cycle after the request is accepted.
- R2: A `cfg_wait` value of 0 gives 32 strobe cycles.
- R3: With `cfg_ack_en`=1, `ack_in` is first looked at in the last counted strobe cycle, and a high level before that cycle has no effect. The strobe ends after the first cycle, at or after the counted length, in which `ack_in` is 1. With `cfg_wait`=1 and `ack_in` already high, the strobe lasts one cycle.
- R4: A read (`req_write`=0) asserts `rd_stb` and never `wr_stb`. `rd_data` takes the value `mem_rdata` has in the last strobe cycle and keeps it until the next read ends.
- R5: A write (`req_write`=1) asserts `wr_stb` and never `rd_stb`. It is followed by `cfg_hold` (0 to 7) hold cycles in which both strobes are low.
- R6: Throughout the strobe and hold cycles, `mem_addr`, `mem_wdata` and `bank_sel` keep the values of the request, and `data_oe` stays high for a write. Reads get no hold cycles, whatever `cfg_hold` is.
- R7: `done` is high for exactly one cycle, right after the last strobe or hold cycle, and `ready` is high in the cycle after that.
- R8: A request is accepted only while `ready`=1. A `req_valid` during a busy access changes neither the address nor anything else, and it starts no second access.
- R9: During strobe and hold cycles, `bank_sel` is one-hot with bit `req_bank` set. Outside them it is zero. `data_oe` is zero for reads and while idle.
- R10: After reset: `ready`=1, `rd_stb`=`wr_stb`=`done`=`data_oe`=0, `bank_sel`=0 and `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present; taken only when ready=1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_bank | input | BANK_IW | Bank index |
| cfg_wait | input | 5 | Wait-state count, 0 means 32 |
| cfg_ack_en | input | 1 | Extend access by acknowledge |
| cfg_hold | input | 3 | Hold cycles after a write |
| ack_in | input | 1 | Device acknowledge, high = finish |
| mem_rdata | input | DATA_W | Data from the device |
| ready | output | 1 | Idle, able to accept a request |
| rd_stb | output | 1 | Read strobe, active high |
| wr_stb | output | 1 | Write strobe, active high |
| mem_addr | output | ADDR_W | Address to the device |
| mem_wdata | output | DATA_W | Write data to the device |
| data_oe | output | 1 | Write data drive enable |
| bank_sel | output | NUM_BANKS | One-hot bank select |
| rd_data | output | DATA_W | Captured read data |
| done | output | 1 | One-cycle end-of-access pulse |

## Verification
Two things can fall in the same cycle: the wait count running out and the first look at acknowledge. The bench drives `ack_in` as a function of the strobe cycle number. It raises acknowledge well before the count ends, exactly on the last counted cycle, one cycle later and many cycles later. It then judges the measured strobe length against max(count, acknowledge cycle). The end of the strobe is also the cycle in which read data is captured. So the bench changes `mem_rdata` every strobe cycle and checks that `rd_data` holds the value of the final one.

// File: rtl/amseq_pkg.sv
package amseq_pkg;

    localparam int WAIT_W = 5;
    localparam int HOLD_W = 3;
    localparam int WCNT_W = WAIT_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_STROBE = 3'd1,
        ST_ACKW   = 3'd2,
        ST_HOLD   = 3'd3,
        ST_DONE   = 3'd4
    } seq_state_e;

    // A field value of zero selects the longest wait.
    function automatic logic [WCNT_W-1:0] eff_wait(input logic [WAIT_W-1:0] w);
        return (w == '0) ? WCNT_W'(1 << WAIT_W) : {1'b0, w};
    endfunction

endpackage

// File: rtl/amseq_downcnt.sv
module amseq_downcnt #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (dec && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == W'(1));

    // R1
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (cnt_q != '0));

endmodule

// File: rtl/amseq_rdcap.sv
module amseq_rdcap #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (capture) data_d = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign dout = data_q;

endmodule

// File: rtl/async_mem_seq.sv
module async_mem_seq
    import amseq_pkg::*;
#(
    parameter  int ADDR_W    = 24,
    parameter  int DATA_W    = 32,
    parameter  int NUM_BANKS = 4,
    localparam int BANK_IW   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [BANK_IW-1:0]   req_bank,
    input  logic [WAIT_W-1:0]    cfg_wait,
    input  logic                 cfg_ack_en,
    input  logic [HOLD_W-1:0]    cfg_hold,
    input  logic                 ack_in,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic                 ready,
    output logic                 rd_stb,
    output logic                 wr_stb,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    output logic                 data_oe,
    output logic [NUM_BANKS-1:0] bank_sel,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 done
);

    typedef struct packed {
        seq_state_e          st;
        logic                wr;
        logic                ack_en;
        logic [HOLD_W-1:0]   hold;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic [BANK_IW-1:0]  bank;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic accept, wait_last, hold_last, strobe_end, in_strobe, active;

    assign accept    = (r_q.st == ST_IDLE) && req_valid;
    assign in_strobe = (r_q.st == ST_STROBE) || (r_q.st == ST_ACKW);
    assign active    = in_strobe || (r_q.st == ST_HOLD);
    assign strobe_end = ((r_q.st == ST_STROBE) && wait_last && (!r_q.ack_en || ack_in))
                     || ((r_q.st == ST_ACKW) && ack_in);

    amseq_downcnt #(.W(WCNT_W)) u_wait_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (eff_wait(cfg_wait)),
        .dec      (r_q.st == ST_STROBE),
        .last     (wait_last)
    );

    amseq_downcnt #(.W(HOLD_W)) u_hold_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (strobe_end && r_q.wr),
        .load_val (r_q.hold),
        .dec      (r_q.st == ST_HOLD),
        .last     (hold_last)
    );

    amseq_rdcap #(.DATA_W(DATA_W)) u_rdcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (strobe_end && !r_q.wr),
        .din     (mem_rdata),
        .dout    (rd_data)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st     = ST_STROBE;
                    r_d.wr     = req_write;
                    r_d.ack_en = cfg_ack_en;
                    r_d.hold   = cfg_hold;
                    r_d.addr   = req_addr;
                    r_d.wdata  = req_wdata;
                    r_d.bank   = req_bank;
                end
            end
            ST_STROBE: begin
                if (wait_last) begin
                    if (r_q.ack_en && !ack_in)
                        r_d.st = ST_ACKW;
                    else
                        r_d.st = (r_q.wr && r_q.hold != '0) ? ST_HOLD : ST_DONE;
                end
            end
            ST_ACKW: begin
                if (ack_in)
                    r_d.st = (r_q.wr && r_q.hold != '0) ? ST_HOLD : ST_DONE;
            end
            ST_HOLD: begin
                if (hold_last) r_d.st = ST_DONE;
            end
            ST_DONE:  r_d.st = ST_IDLE;
            default:  r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign ready     = (r_q.st == ST_IDLE);
    assign done      = (r_q.st == ST_DONE);
    assign rd_stb    = in_strobe && !r_q.wr;
    assign wr_stb    = in_strobe && r_q.wr;
    assign data_oe   = active && r_q.wr;
    assign mem_addr  = r_q.addr;
    assign mem_wdata = r_q.wdata;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign bank_sel[b] = active && (r_q.bank == BANK_IW'(b));
    end

    // R1
    strobe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid) |=> (rd_stb || wr_stb));

    // R3
    early_ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_STROBE) && !wait_last) |=> (rd_stb || wr_stb));

    // R3
    ack_extend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_strobe && r_q.ack_en && !ack_in && (wait_last || r_q.st == ST_ACKW))
        |=> (rd_stb || wr_stb));

    // R5
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HOLD) |-> (!rd_stb && !wr_stb && data_oe));

    // R6
    bus_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> ($stable(mem_addr) && $stable(mem_wdata) && $stable(bank_sel)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && ready));

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && req_valid) |=> $stable(mem_addr));

    // R9
    bank_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb || wr_stb) |-> ($countones(bank_sel) == 1));

endmodule

// File: tb/tb_async_mem_seq.sv
module tb_async_mem_seq;

    localparam int ADDR_W = 24;
    localparam int DATA_W = 32;
    localparam int NB     = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [1:0]        req_bank = '0;
    logic [4:0]        cfg_wait = 5'd1;
    logic              cfg_ack_en = 1'b0;
    logic [2:0]        cfg_hold = '0;
    logic              ack_in = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              ready, rd_stb, wr_stb, data_oe, done;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, rd_data;
    logic [NB-1:0]     bank_sel;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    async_mem_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BANKS(NB)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_bank(req_bank),
        .cfg_wait(cfg_wait), .cfg_ack_en(cfg_ack_en), .cfg_hold(cfg_hold),
        .ack_in(ack_in), .mem_rdata(mem_rdata), .ready(ready), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .data_oe(data_oe), .bank_sel(bank_sel), .rd_data(rd_data), .done(done)
    );

    typedef struct packed {
        logic       wr;
        logic [4:0] ws;
        logic       ack_en;
        logic [2:0] hold;
        logic [5:0] ack_at;
        logic [1:0] bank;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 5'd3,  1'b0, 3'd0, 6'd0,  2'd0},
        '{1'b1, 5'd3,  1'b0, 3'd2, 6'd0,  2'd1},
        '{1'b0, 5'd0,  1'b0, 3'd0, 6'd0,  2'd2},
        '{1'b1, 5'd31, 1'b0, 3'd7, 6'd0,  2'd3},
        '{1'b0, 5'd4,  1'b1, 3'd0, 6'd1,  2'd0},
        '{1'b0, 5'd4,  1'b1, 3'd0, 6'd4,  2'd1},
        '{1'b0, 5'd4,  1'b1, 3'd0, 6'd5,  2'd2},
        '{1'b1, 5'd2,  1'b1, 3'd1, 6'd9,  2'd3},
        '{1'b0, 5'd1,  1'b1, 3'd0, 6'd1,  2'd0},
        '{1'b1, 5'd5,  1'b0, 3'd0, 6'd0,  2'd1},
        '{1'b0, 5'd2,  1'b0, 3'd3, 6'd0,  2'd2}
    };

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Runs one access; called at a negedge with ready=1. Returns at the negedge after done.
    task automatic run_access(input int idx, input vec_t v);
        int eff, exp_s, exp_h, s, h, d, bad, tail;
        logic [ADDR_W-1:0] ea;
        logic [DATA_W-1:0] ew, base;
        logic [NB-1:0]     eb;
        string sreq;
        eff   = (v.ws == 0) ? 32 : int'(v.ws);
        exp_s = (v.ack_en && int'(v.ack_at) > eff) ? int'(v.ack_at) : eff;
        exp_h = v.wr ? int'(v.hold) : 0;
        ea    = ADDR_W'(24'h100000 + idx * 16);
        ew    = 32'hC0DE0000 + DATA_W'(idx);
        eb    = NB'(1) << v.bank;
        base  = 32'hA5A50000 ^ DATA_W'(idx << 8);
        sreq  = v.ack_en ? "R3" : ((v.ws == 0) ? "R2" : "R1");
        req_valid = 1'b1; req_write = v.wr; req_addr = ea; req_wdata = ew;
        req_bank = v.bank; cfg_wait = v.ws; cfg_ack_en = v.ack_en; cfg_hold = v.hold;
        @(negedge clk);
        req_valid = 1'b0;
        s = 0; h = 0; d = 0; bad = 0; tail = 0;
        for (int c = 0; c < 80; c++) begin
            if (rd_stb || wr_stb) begin
                s++;
                ack_in    = v.ack_en && (s >= int'(v.ack_at));
                mem_rdata = base ^ DATA_W'(s);
                if (wr_stb != v.wr || rd_stb == v.wr) bad++;
                if (mem_addr != ea || bank_sel != eb || data_oe != v.wr) bad++;
                if (v.wr && mem_wdata != ew) bad++;
            end else if (done) begin
                d++;
                ack_in = 1'b0;
                break;
            end else begin
                ack_in = 1'b0;
                h++;
                if (!data_oe || mem_addr != ea || mem_wdata != ew || bank_sel != eb) bad++;
            end
            @(negedge clk);
        end
        chk(sreq, $sformatf("vec%0d strobe length", idx), s, exp_s);
        chk(v.wr ? "R5" : "R6", $sformatf("vec%0d hold length", idx), h, exp_h);
        chk("R6", $sformatf("vec%0d bus integrity", idx), bad, 0);
        if (!v.wr)
            chk("R4", $sformatf("vec%0d read capture", idx), rd_data, base ^ DATA_W'(exp_s));
        @(negedge clk);
        if (done || !ready) tail = 1;
        chk("R7", $sformatf("vec%0d done pulse", idx), {d[0], tail[0]}, 2'b10);
        chk("R9", $sformatf("vec%0d idle bank", idx), bank_sel, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] saved;
        int extra;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10", "ready", ready, 1);
        chk("R10", "strobes/done/oe", {rd_stb, wr_stb, done, data_oe}, 0);
        chk("R10", "bank_sel", bank_sel, 0);
        chk("R10", "rd_data", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) run_access(i, VECS[i]);

        // R8: request during a busy write is ignored
        saved = rd_data;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 24'h0ABCDE;
        req_wdata = 32'h11112222; req_bank = 2'd2;
        cfg_wait = 5'd6; cfg_ack_en = 1'b0; cfg_hold = 3'd1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 24'h055555; req_bank = 2'd0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8", "address kept while busy", mem_addr, 24'h0ABCDE);
        chk("R8", "direction kept while busy", {wr_stb, rd_stb}, 2'b10);
        while (!done) @(negedge clk);
        @(negedge clk);
        extra = 0;
        for (int k = 0; k < 4; k++) begin
            if (rd_stb || wr_stb) extra++;
            @(negedge clk);
        end
        chk("R8", "no second access", extra, 0);
        chk("R4", "rd_data kept across write", rd_data, saved);
        chk("R9", "data_oe idle", data_oe, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule